// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Protected Status Flags

This block is one timer channel built around a 16-bit counter that runs freely, advancing by one on every clock. It has four general registers, named A to D. A mode bit selects, for each register, whether the register compares against the counter or captures it. In compare mode the register raises a match when the counter equals it. In capture mode the register samples the counter on a rising edge at its capture pin.

An 8-bit status register collects the events of the channel. These are the counter overflow and the four capture/compare events. The same register also holds three events from a neighbouring, smaller channel, which arrive as one-cycle set pulses.

Software cannot clear a status flag by accident. A flag is cleared only by a read of the status register that shows the flag at 1, followed by a write of 0 to that bit. Each flag can drive the single interrupt request through its own enable bit.

Top module: `cc_timer_status`

The bus address map is as follows. Address 0 is status. Address 1 is the interrupt enable, with one bit per status bit. Address 2 is the mode register: bit j controls register j, with A=0 and D=3, and 1 means capture. Address 3 is the counter. Addresses 4 to 7 are general registers A to D. Reads return the value zero-extended to 16 bits.

## Requirements
- R1: After a synchronous active-low reset, the counter is 0, every status flag is 0, the enable and mode registers are 0 (all compare), and every general register holds 0xFFFF.
- R2: The status layout is as follows. Bit 7 is the overflow of this channel. Bits 6, 5, 4 and 3 are the events of registers D, C, B and A. Bits 2, 1 and 0 are the neighbour's overflow, register B and register A events.
- R3: The counter adds one on every clock and takes the bus value when written at address 3. The overflow flag (bit 7) sets on the clock at which the counter rolls from 0xFFFF to 0x0000 by counting.
- R4: When register j is in compare mode, its flag (bit 3+j) sets, and `cmp_match[j]` pulses high for one cycle, on the clock after the one in which the counter equals the register.
- R5: A capture pin passes through a two-flop synchronizer, and only a rising edge counts. If the pin is first seen high at clock edge E, the register in capture mode loads the counter value that was present after edge E+1. Its flag sets at edge E+2. A pin held high does not capture again.
- R6: A bus write to a general register in capture mode is ignored. A capture pin of a register in compare mode has no effect. Registers in compare mode accept bus writes.
- R7: Writing 1 to a status bit leaves that flag unchanged.
- R8: Each flag has an arm bit. The arm bit is set by a status read that returns the flag as 1, and it is cleared by any status write. A write of 0 clears the flag only while its arm bit is set. A read taken while the flag was 0 does not arm it.
- R9: If a flag's set event and a valid clear fall in the same cycle, the flag stays 1.
- R10: `irq` is high exactly when some status flag is 1 and the enable bit at the same position is 1.
- R11: A one-cycle pulse on `ch2_set[k]` sets status bit k, for k from 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle (arms status flags) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| cap_pin | input | 4 | Capture pins for registers A to D, asynchronous |
| ch2_set | input | 3 | Set pulses from the neighbouring channel |
| cmp_match | output | 4 | Compare-match pulses for registers A to D |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs each of the eight flags through the full clear protocol. It tries a write of 0 with no read before it, a write of 1, a write of 0 after the arm bit was used up, and finally a valid read-then-write-0. A design that clears without the read, or that keeps the arm bit across writes, leaves a flag in the wrong state. The bench also pins down the exact compare and capture cycles, where one extra or missing register stage shifts the flag or the captured count by one. It checks the set-wins collision, a read taken before the flag was set, a capture pin held high, and a bus write into a capture-mode register. Each of these catches a design that clears, captures or overwrites when it must not.

// File: rtl/cct_pkg.sv
// Package: register address map for the capture/compare timer channel.
// Assumes a 3-bit word address and at most four general registers.
package cct_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MODE = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_GR0  = 3'd4;
endpackage

// File: rtl/cct_counter.sv
// Free-running up-counter. It advances every clock, can be loaded from the bus,
// and flags a wrap when it counts out of the all-ones value.
// Assumes that a load takes priority over counting and never reports a wrap.
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    // count, or take the loaded value
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (ld) cnt <= ld_val;
        else         cnt <= cnt + 1'b1;
    end

    // the wrap event is the final count before rolling to zero
    assign wrap = !ld && (cnt == {W{1'b1}});

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0)); // R3
endmodule

// File: rtl/cct_gen_reg.sv
// One general register. In compare mode it matches against the counter.
// In capture mode it loads the counter on a synchronized rising edge of its pin.
// Assumes the pin is asynchronous, so it goes through two flops plus an edge flop.
module cct_gen_reg #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_mode,
    input  logic         pin,
    input  logic [W-1:0] cnt,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] gr,
    output logic         hit,
    output logic         match_q
);
    logic sync1, sync2, sync3;
    logic rise, cap_evt, eq;

    // synchronize the pin and keep the previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) {sync1, sync2, sync3} <= '0;
        else        {sync1, sync2, sync3} <= {pin, sync1, sync2};
    end

    assign rise    = sync2 && !sync3;
    assign cap_evt = rise && cap_mode;
    assign eq      = !cap_mode && (cnt == gr);
    assign hit     = cap_evt || eq;

    // capture the counter, or take a bus write while in compare mode
    always_ff @(posedge clk) begin
        if (!rst_n)              gr <= RST_VAL;
        else if (cap_evt)        gr <= cnt;
        else if (wr && !cap_mode) gr <= wdata;
    end

    // registered compare-match pulse
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= eq;
    end

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (gr == $past(cnt))); // R5
    AST_CAPTURE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && wr && !cap_evt) |=> $stable(gr)); // R6
endmodule

// File: rtl/cct_flag_bank.sv
// Status flags with read-then-write-zero clearing and interrupt combining.
// Assumes one bus operation per cycle. A status write consumes every arm bit.
module cct_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         rd_stat,
    input  logic         wr_stat,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] ien,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] arm;
    logic [N-1:0] clr;

    // arm bits: a write consumes them, a read arms the flags seen at 1
    always_ff @(posedge clk) begin
        if (!rst_n)       arm <= '0;
        else if (wr_stat) arm <= '0;
        else if (rd_stat) arm <= arm | flags;
    end

    assign clr = {N{wr_stat}} & ~wdata & arm;

    // flag update: a set event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= set | (flags & ~clr);
    end

    assign irq = |(flags & ien);

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]); // R9
        AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(arm[i] && wr_stat && !wdata[i])); // R8
        AST_WRITE_ONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && wr_stat && wdata[i]) |=> flags[i]); // R7
    end
endmodule

// File: rtl/cc_timer_status.sv
// Capture/compare timer channel with a protected 8-bit status register.
// It holds the bus decode, the enable and mode registers, and the status
// bit assembly, and it instantiates the counter, the general registers and
// the flag bank. Assumes single-cycle bus strobes and that reads are
// combinational from bus_addr.
module cc_timer_status
    import cct_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_GR  = 4,
    parameter int N_EXT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [CNT_W-1:0]    bus_wdata,
    output logic [CNT_W-1:0]    bus_rdata,
    input  logic [N_GR-1:0]     cap_pin,
    input  logic [N_EXT-1:0]    ch2_set,
    output logic [N_GR-1:0]     cmp_match,
    output logic                irq
);
    localparam int STAT_W = 1 + N_GR + N_EXT;

    logic [STAT_W-1:0] ien_q;
    logic [N_GR-1:0]   mode_q;
    logic [STAT_W-1:0] flags;
    logic [STAT_W-1:0] set_vec;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic [N_GR-1:0]   hit;
    logic [N_GR-1:0]   gr_wr;
    logic [CNT_W-1:0]  gr_val [N_GR];

    logic stat_wr, stat_rd, ien_wr, mode_wr, cnt_wr;
    assign stat_wr = bus_wr && (bus_addr == ADR_STAT);
    assign stat_rd = bus_rd && (bus_addr == ADR_STAT);
    assign ien_wr  = bus_wr && (bus_addr == ADR_IEN);
    assign mode_wr = bus_wr && (bus_addr == ADR_MODE);
    assign cnt_wr  = bus_wr && (bus_addr == ADR_CNT);

    // enable and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            mode_q <= '0;
        end else begin
            if (ien_wr)  ien_q  <= bus_wdata[STAT_W-1:0];
            if (mode_wr) mode_q <= bus_wdata[N_GR-1:0];
        end
    end

    cct_counter #(.W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .ld(cnt_wr), .ld_val(bus_wdata),
        .cnt(cnt), .wrap(wrap)
    );

    for (genvar j = 0; j < N_GR; j++) begin : g_gr
        assign gr_wr[j] = bus_wr && (bus_addr == ADDR_W'(int'(ADR_GR0) + j));
        cct_gen_reg #(.W(CNT_W), .RST_VAL({CNT_W{1'b1}})) gr_i (
            .clk(clk), .rst_n(rst_n), .cap_mode(mode_q[j]), .pin(cap_pin[j]),
            .cnt(cnt), .wr(gr_wr[j]), .wdata(bus_wdata), .gr(gr_val[j]),
            .hit(hit[j]), .match_q(cmp_match[j])
        );
    end

    // status layout: overflow on top, then register events D..A, then the neighbour
    assign set_vec = {wrap, hit, ch2_set};

    cct_flag_bank #(.N(STAT_W)) flags_i (
        .clk(clk), .rst_n(rst_n), .set(set_vec), .rd_stat(stat_rd),
        .wr_stat(stat_wr), .wdata(bus_wdata[STAT_W-1:0]), .ien(ien_q),
        .flags(flags), .irq(irq)
    );

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_STAT: bus_rdata = CNT_W'(flags);
            ADR_IEN:  bus_rdata = CNT_W'(ien_q);
            ADR_MODE: bus_rdata = CNT_W'(mode_q);
            ADR_CNT:  bus_rdata = cnt;
            default: begin
                for (int j = 0; j < N_GR; j++)
                    if (bus_addr == ADDR_W'(int'(ADR_GR0) + j)) bus_rdata = gr_val[j];
            end
        endcase
    end

    AST_MODE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q[0]) && mode_q[0]) |-> !cmp_match[0]); // R6
endmodule

// File: tb/cc_timer_status_tb_top.sv
// Bench for cc_timer_status. Every test step drives inputs at a falling
// edge and samples the outputs there as well.
module cc_timer_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  cap_pin = '0;
    logic [2:0]  ch2_set = '0;
    logic [3:0]  cmp_match;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] A_STAT = 3'd0, A_IEN = 3'd1, A_MODE = 3'd2,
                           A_CNT = 3'd3, A_GR0 = 3'd4;

    always #10 clk = ~clk;

    cc_timer_status dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .ch2_set(ch2_set), .cmp_match(cmp_match), .irq(irq)
    );

    function automatic logic [15:0] gv(input int j);
        return 16'(16'h2000 * (j + 1));
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_flag(input int i);
        if (i < 3) begin
            ch2_set[i] = 1'b1;
            @(negedge clk);
            ch2_set = '0;
        end else if (i < 7) begin
            wr(A_CNT, gv(i - 3) - 16'd3);
            idle(5);
        end else begin
            wr(A_CNT, 16'hFFFD);
            idle(5);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset values
        rd_chk(A_CNT, 16'h0000, "R1 counter");
        rd_chk(A_STAT, 16'h0000, "R1 status");
        rd_chk(A_IEN, 16'h0000, "R1 enable");
        rd_chk(A_MODE, 16'h0000, "R1 mode");
        rd_chk(A_GR0, 16'hFFFF, "R1 general reg");
        check("R1 irq", 16'(irq), 16'h0);

        // R3 counting after a load
        wr(A_CNT, 16'h0100);
        rd_chk(A_CNT, 16'h0100, "R3 load");
        rd_chk(A_CNT, 16'h0101, "R3 increment");
        rd_chk(A_CNT, 16'h0102, "R3 increment");

        for (int j = 0; j < 4; j++) wr(3'(A_GR0 + 3'(j)), gv(j));
        rd_chk(3'(A_GR0 + 3'd1), gv(1), "R6 compare reg writable");

        // R7/R8 clear protocol swept over all eight flags
        for (int i = 0; i < 8; i++) begin
            set_flag(i);
            wr(A_STAT, 16'h0000);
            rd_chk(A_STAT, 16'(1 << i), i < 3 ? "R11 R2 set, write0 unarmed R8" :
                   (i < 7 ? "R4 R2 set, write0 unarmed R8" : "R3 R2 set, write0 unarmed R8"));
            wr(A_STAT, 16'h00FF);
            rd_chk(A_STAT, 16'(1 << i), "R7 write of one");
            wr(A_STAT, 16'h00FF);
            wr(A_STAT, 16'h0000);
            rd_chk(A_STAT, 16'(1 << i), "R8 arm consumed by write");
            wr(A_STAT, 16'(~(16'd1 << i)));
            rd_chk(A_STAT, 16'h0000, "R8 valid clear");
            check("R10 irq masked", 16'(irq), 16'h0);
        end

        // R4 exact compare cycle on register B
        wr(A_CNT, gv(1) - 16'd3);
        idle(3);
        check("R4 no early match", 16'(cmp_match), 16'h0);
        rd_chk(A_STAT, 16'h0000, "R4 no early flag");
        check("R4 match pulse", 16'(cmp_match), 16'h2);
        rd_chk(A_STAT, 16'h0010, "R4 flag bit4");
        check("R4 pulse one cycle", 16'(cmp_match), 16'h0);
        wr(A_STAT, 16'hFFEF);
        rd_chk(A_STAT, 16'h0000, "R8 clear bit4");

        // R8 read while flag was 0 does not arm
        rd_chk(A_STAT, 16'h0000, "R8 pre-read");
        set_flag(0);
        wr(A_STAT, 16'h0000);
        rd_chk(A_STAT, 16'h0001, "R8 read before set");
        wr(A_STAT, 16'hFFFE);
        rd_chk(A_STAT, 16'h0000, "R8 clear bit0");

        // R9 set and clear in the same cycle
        set_flag(1);
        rd_chk(A_STAT, 16'h0002, "R11 bit1");
        bus_addr = A_STAT; bus_wdata = 16'h0000; bus_wr = 1'b1; ch2_set = 3'b010;
        @(negedge clk);
        bus_wr = 1'b0; ch2_set = '0;
        rd_chk(A_STAT, 16'h0002, "R9 set wins");
        wr(A_STAT, 16'h0000);
        rd_chk(A_STAT, 16'h0000, "R9 cleared afterwards");

        // R10 interrupt enable sweep
        for (int i = 0; i < 8; i++) set_flag(i);
        check("R10 no enable", 16'(irq), 16'h0);
        for (int k = 0; k < 8; k++) begin
            wr(A_IEN, 16'(1 << k));
            check("R10 single enable", 16'(irq), 16'h1);
        end
        rd_chk(A_STAT, 16'h00FF, "R2 all flags");
        wr(A_STAT, 16'h0000);
        wr(A_IEN, 16'h00FF);
        check("R10 no flags", 16'(irq), 16'h0);
        set_flag(2);
        check("R10 flag enabled", 16'(irq), 16'h1);
        wr(A_IEN, 16'h00FB);
        check("R10 flag masked", 16'(irq), 16'h0);
        rd_chk(A_STAT, 16'h0004, "R11 bit2");
        wr(A_STAT, 16'h0000);
        wr(A_IEN, 16'h0000);

        // R5 capture on register A
        wr(A_MODE, 16'h0001);
        rd_chk(A_MODE, 16'h0001, "R5 mode readback");
        wr(A_CNT, 16'h1234);
        cap_pin[0] = 1'b1;
        idle(2);
        rd_chk(A_STAT, 16'h0000, "R5 not yet captured");
        rd_chk(A_STAT, 16'h0008, "R5 capture flag");
        rd_chk(A_GR0, 16'h1236, "R5 captured count");
        wr(A_GR0, 16'h5555);
        rd_chk(A_GR0, 16'h1236, "R6 write ignored in capture");
        rd_chk(A_STAT, 16'h0008, "R5 flag held");
        wr(A_STAT, 16'hFFF7);
        idle(6);
        rd_chk(A_STAT, 16'h0000, "R5 held pin no retrigger");
        cap_pin = '0;

        // R6 pin of a compare register ignored
        cap_pin[1] = 1'b1;
        idle(6);
        rd_chk(A_STAT, 16'h0000, "R6 compare pin ignored");
        rd_chk(3'(A_GR0 + 3'd1), gv(1), "R6 compare reg kept");
        cap_pin = '0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule